// File: doc/BRIEF.md
# Pixel Shift and Mask Assist Unit

This block helps software move packed 4-bit pixel words to positions that do not line up with a word boundary, and combine them with a background through a transparency mask. Software writes a source word into the shift data register, then writes a pixel count into the count register. It can then read three results: the source moved right by that many whole pixels, the pixels that fell off the right edge, and a mask of the moved word. A fourth register returns the mask of any word written to it, with no shifting.

A mask marks every nonzero pixel with an all-ones nibble and every zero pixel with a zero nibble. Software inverts the mask, ANDs it with the background, and ORs in the foreground. Pixel value zero therefore acts as transparent. Within a word, the most significant nibble is the leftmost pixel.

The block sits on a simple register bus with single-cycle write and read strobes. It has no back-pressure: every write takes effect at the clock edge it is sampled on. Read data is a combinational function of the offset and the stored state, so it is valid in the same cycle as the read strobe. It is zero whenever no read is asserted or the offset is not mapped. A read issued in the same cycle as a write shows the state from before that write.

Top module: `pixshift_assist`

## Requirements
- R1: After reset, the source word, the count and the mask generator input are zero, so every readable register returns 0x00000000.
- R2: A write to the shift data offset (0x918) stores the word and sets the count to zero. A read of that offset right afterwards returns the word unchanged.
- R3: A write to the count offset (0x91C) stores only bits 2:0 of the write data and ignores every higher bit.
- R4: A read of the shift data offset returns the source shifted right by 4 × count bits, with zeros filling in from the left.
- R5: A read of the spill offset (0x924) returns the pixels shifted out on the right, placed in the top nibbles in their original order, with all other bits zero. A count of zero gives a spill of zero.
- R6: The mask of a word has nibble i equal to 0xF when pixel nibble i is nonzero, and 0x0 otherwise. Examples: 0x00000001 gives 0x0000000F, 0x0407000F gives 0x0F0F000F, and 0x1234ABC0 gives 0xFFFFFFF0.
- R7: A read of the shifted mask offset (0x920) returns the R6 mask of the R4 shifted word.
- R8: A write to the mask generator offset (0x928) stores a word, and a read of that offset returns its R6 mask.
- R9: The count offset cannot be read (a read returns zero), and any unmapped offset also reads as zero.
- R10: rdata is zero in every cycle in which rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 12 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the same cycle as rd_en |

## Verification
The source word 0x12345678 is shifted by every count from 0 to 7. Because its pixels are all distinct, the test shows whether the shift runs the wrong way, whether the spill nibbles come back reversed, and whether any nibble is off by one. Sparse words that mix zero and nonzero pixels, including a single low pixel and a lone nonzero value in each nibble position, test the mask for bits dropped within a nibble. Count writes with high bits set show that only the low three bits are used, and a reload after a count write shows that the count is cleared.

// File: rtl/pixshift_pkg.sv
package pixshift_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SRC,
    SEL_CNT,
    SEL_SMASK,
    SEL_SPILL,
    SEL_MGEN
  } reg_sel_e;
endpackage

// File: rtl/pixshift_decode.sv
module pixshift_decode
  import pixshift_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE = 12'h918
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam logic [ADDR_W-1:0] OFS_SRC   = BASE;
  localparam logic [ADDR_W-1:0] OFS_CNT   = BASE + ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_SMASK = BASE + ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFS_SPILL = BASE + ADDR_W'(12);
  localparam logic [ADDR_W-1:0] OFS_MGEN  = BASE + ADDR_W'(16);

  always_comb begin
    unique case (addr)
      OFS_SRC:   sel = SEL_SRC;
      OFS_CNT:   sel = SEL_CNT;
      OFS_SMASK: sel = SEL_SMASK;
      OFS_SPILL: sel = SEL_SPILL;
      OFS_MGEN:  sel = SEL_MGEN;
      default:   sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/pix_shifter.sv
module pix_shifter #(
  parameter int PIX_W  = 4,
  parameter int WORD_W = 32,
  localparam int NPIX  = WORD_W / PIX_W,
  localparam int CNT_W = $clog2(NPIX)
) (
  input  logic [WORD_W-1:0] src,
  input  logic [CNT_W-1:0]  cnt,
  output logic [WORD_W-1:0] shifted,
  output logic [WORD_W-1:0] spill
);
  // Nibble j of both outputs takes source nibble (j + cnt) taken modulo NPIX.
  // The ones that did not wrap go to the shifted word, the ones that wrapped go to the spill.
  always_comb begin
    shifted = '0;
    spill   = '0;
    for (int j = 0; j < NPIX; j++) begin
      int idx;
      idx = j + int'(cnt);
      if (idx < NPIX)
        shifted[j*PIX_W +: PIX_W] = src[idx*PIX_W +: PIX_W];
      else
        spill[j*PIX_W +: PIX_W] = src[(idx-NPIX)*PIX_W +: PIX_W];
    end
  end
endmodule

// File: rtl/nib_mask.sv
module nib_mask #(
  parameter int PIX_W  = 4,
  parameter int WORD_W = 32,
  localparam int NPIX  = WORD_W / PIX_W
) (
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] mask
);
  for (genvar g = 0; g < NPIX; g++) begin : g_pix
    assign mask[g*PIX_W +: PIX_W] = {PIX_W{|word[g*PIX_W +: PIX_W]}};
  end
endmodule

// File: rtl/pixshift_assist.sv
module pixshift_assist
  import pixshift_pkg::*;
#(
  parameter int PIX_W  = 4,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE = 12'h918
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int NPIX  = WORD_W / PIX_W;
  localparam int CNT_W = $clog2(NPIX);

  reg_sel_e          sel;
  logic [WORD_W-1:0] src_q, mgen_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shifted, spill, smask, gmask;

  pixshift_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .addr (addr),
    .sel  (sel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      cnt_q  <= '0;
      mgen_q <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_SRC: begin
          src_q <= wdata;
          cnt_q <= '0;
        end
        SEL_CNT:  cnt_q  <= wdata[CNT_W-1:0];
        SEL_MGEN: mgen_q <= wdata;
        default: ;
      endcase
    end
  end

  pix_shifter #(.PIX_W(PIX_W), .WORD_W(WORD_W)) u_shf (
    .src     (src_q),
    .cnt     (cnt_q),
    .shifted (shifted),
    .spill   (spill)
  );

  nib_mask #(.PIX_W(PIX_W), .WORD_W(WORD_W)) u_smask (
    .word (shifted),
    .mask (smask)
  );

  nib_mask #(.PIX_W(PIX_W), .WORD_W(WORD_W)) u_gmask (
    .word (mgen_q),
    .mask (gmask)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (sel)
        SEL_SRC:   rdata = shifted;
        SEL_SMASK: rdata = smask;
        SEL_SPILL: rdata = spill;
        SEL_MGEN:  rdata = gmask;
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pixshift_assist_chk.sv
module pixshift_assist_chk #(
  parameter int PIX_W  = 4,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE = 12'h918,
  localparam int CNT_W = $clog2(WORD_W / PIX_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [WORD_W-1:0] wdata,
  input logic [WORD_W-1:0] rdata,
  input logic [WORD_W-1:0] src_q,
  input logic [CNT_W-1:0]  cnt_q
);
  localparam logic [ADDR_W-1:0] A_SRC   = BASE;
  localparam logic [ADDR_W-1:0] A_CNT   = BASE + ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_SPILL = BASE + ADDR_W'(12);

  a_r2_load_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SRC) |=> (cnt_q == '0 && src_q == $past(wdata)));

  a_r3_count_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CNT) |=> (cnt_q == $past(wdata[CNT_W-1:0])));

  a_r4_zero_count_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_SRC && cnt_q == '0) |-> (rdata == src_q));

  a_r5_zero_count_no_spill: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_SPILL && cnt_q == '0) |-> (rdata == '0));

  a_r9_count_unreadable: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_CNT) |-> (rdata == '0));

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == '0));
endmodule

bind pixshift_assist pixshift_assist_chk #(
  .PIX_W(PIX_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .BASE(BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .src_q(src_q), .cnt_q(cnt_q)
);

// File: tb/sim_pixshift_assist.sv
module sim_pixshift_assist;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] O_SRC = 12'h918, O_CNT = 12'h91C, O_SMASK = 12'h920,
                          O_SPILL = 12'h924, O_MGEN = 12'h928;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixshift_assist u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  function automatic logic [31:0] ref_mask(input logic [31:0] w);
    logic [31:0] m = '0;
    for (int k = 0; k < 8; k++)
      if (w[k*4 +: 4] != 4'h0) m[k*4 +: 4] = 4'hF;
    return m;
  endfunction

  function automatic logic [31:0] ref_shift(input logic [31:0] w, input int c);
    return w >> (4*c);
  endfunction

  function automatic logic [31:0] ref_spill(input logic [31:0] w, input int c);
    if (c == 0) return 32'h0;
    return w << (32 - 4*c);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bus_read(O_SRC, d);   check("R1 src after reset", d, 32'h0);
    bus_read(O_SMASK, d); check("R1 smask after reset", d, 32'h0);
    bus_read(O_SPILL, d); check("R1 spill after reset", d, 32'h0);
    bus_read(O_MGEN, d);  check("R1 mgen after reset", d, 32'h0);
  endtask

  task automatic t_maskgen;
    logic [31:0] pats [5] = '{32'h0, 32'h1, 32'h0407000F, 32'h1234ABC0, 32'h80402010};
    logic [31:0] d;
    foreach (pats[i]) begin
      bus_write(O_MGEN, pats[i]);
      bus_read(O_MGEN, d);
      check("R6 R8 mask generator", d, ref_mask(pats[i]));
    end
    check("R6 example table", ref_mask(32'h0407000F), 32'h0F0F000F);
  endtask

  task automatic t_sweep(input logic [31:0] s);
    logic [31:0] d;
    bus_write(O_SRC, s);
    for (int c = 0; c < 8; c++) begin
      bus_write(O_CNT, 32'(c));
      bus_read(O_SRC, d);   check("R4 shifted", d, ref_shift(s, c));
      bus_read(O_SPILL, d); check("R5 spill", d, ref_spill(s, c));
      bus_read(O_SMASK, d); check("R7 shifted mask", d, ref_mask(ref_shift(s, c)));
    end
  endtask

  task automatic t_count_bits;
    logic [31:0] d;
    bus_write(O_SRC, 32'h12345678);
    bus_write(O_CNT, 32'h0000_01F3);
    bus_read(O_SRC, d); check("R3 high count bits ignored", d, 32'h00012345);
    bus_read(O_SPILL, d); check("R3 spill with masked count", d, 32'h67800000);
    bus_write(O_CNT, 32'hFFFF_FFF8);
    bus_read(O_SRC, d); check("R3 count 8 acts as 0", d, 32'h12345678);
  endtask

  task automatic t_reload;
    logic [31:0] d;
    bus_write(O_SRC, 32'hAAAAAAAA);
    bus_write(O_CNT, 32'd5);
    bus_write(O_SRC, 32'hC0FFEE01);
    bus_read(O_SRC, d);   check("R2 reload clears count", d, 32'hC0FFEE01);
    bus_read(O_SPILL, d); check("R2 spill zero after reload", d, 32'h0);
  endtask

  task automatic t_unreadable;
    logic [31:0] d;
    bus_write(O_CNT, 32'd3);
    bus_read(O_CNT, d);   check("R9 count reads zero", d, 32'h0);
    bus_read(12'h92C, d); check("R9 unmapped reads zero", d, 32'h0);
    @(negedge clk); addr = O_SRC; #1;
    check("R10 idle rdata zero", rdata, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_maskgen();
    t_sweep(32'h12345678);
    t_sweep(32'hF0E00D01);
    t_count_bits();
    t_reload();
    t_unreadable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule